// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Sequencer

This block paces a serial display host that runs in video mode. It counts lane byte clock cycles across each line and lines across each frame, and reports at every cycle which region the link is in: horizontal sync, horizontal back porch, active pixels, horizontal front porch, or vertical blanking. It also raises strobes when a frame starts, when a line's sync starts and ends, and when a pixel packet may begin. A companion flag tells the lane logic when the current blanking region may drop to low power.

All timing comes from static inputs. The horizontal values are byte-clock counts. The vertical values are line counts. The active span is derived from the pixels per line and the lane count, at 3 bytes per pixel. Every input except the run condition is captured at a frame start and held for the whole frame. Packet encoding, pixel data and the physical lanes belong to other blocks.

Top module: `vid_timing_seq`

## Requirements
- R1: While `pwr_on` is 0 or `cmd_mode` is 1, `region` is 0 (idle) one cycle after that condition is sampled, and `frame_start` is 0. When video mode is then selected with power on, the first `frame_start` appears one cycle after the run condition is sampled.
- R2: Each line starts with `hsync_cyc` cycles of region 1 (sync). On active lines, `hbp_cyc` cycles of region 2 (back porch), the active span in region 3, and then region 4 (front porch) follow, up to a line length of `line_cyc`.
- R3: The active span is ceil(3 * `pix_per_line` / L) cycles, where L = `lanes_m1` + 1.
- R4: If sync + back porch + active span exceeds `line_cyc`, the front porch is zero and the line lasts that sum instead.
- R5: A frame runs `vsync_lines` sync lines, then `vbp_lines` back-porch lines, then the active lines, then `vfp_lines` front-porch lines, and then wraps. `vphase` reports these as 0, 1, 2 and 3. An active count of 0 is treated as 1. On every line outside the active lines, the cycles after sync are region 5 (vertical blanking).
- R6: `sync_start` pulses on cycle 0 of every line. `frame_start` pulses on cycle 0 of the first line of the frame.
- R7: `pkt_start` pulses on the first active cycle of each active line, provided the span is non-zero.
- R8: `vid_mode` 0 (sync pulses) pulses `sync_end` at cycle `hsync_cyc` of every line when `hsync_cyc` is non-zero. Modes 1 (sync events), 2 (burst) and 3 (treated as events) never pulse it.
- R9: `lp_allow` follows `lp_en`. Bit 0 covers vertical blanking in sync lines, bit 1 in back-porch lines and bit 2 in front-porch lines. Bit 3 gates all horizontal blanking on active lines. Within that gate, bit 4 covers the back porch and bit 5 the front porch. Burst mode makes the front porch eligible regardless of bit 5. Sync and active cycles are never eligible.
- R10: A change to any timing, mode or mask input takes effect only from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Active-low reset |
| pwr_on | input | 1 | Core powered up |
| cmd_mode | input | 1 | 1 selects command mode, 0 selects video mode |
| vid_mode | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| lp_en | input | 6 | Low-power eligibility mask per region |
| lanes_m1 | input | 2 | Lane count minus one |
| pix_per_line | input | PW | Pixels per active packet |
| hsync_cyc | input | HW | Horizontal sync width, cycles |
| hbp_cyc | input | HW | Horizontal back porch, cycles |
| line_cyc | input | HW | Total line time, cycles |
| vsync_lines | input | VW | Vertical sync lines |
| vbp_lines | input | VW | Vertical back-porch lines |
| vact_lines | input | VW | Active lines |
| vfp_lines | input | VW | Vertical front-porch lines |
| region | output | 3 | 0 idle, 1 sync, 2 back porch, 3 active, 4 front porch, 5 vertical blanking |
| vphase | output | 2 | Vertical phase of the current line |
| lp_allow | output | 1 | Current region may use low power |
| frame_start | output | 1 | First cycle of a frame |
| sync_start | output | 1 | First cycle of a line |
| sync_end | output | 1 | End of horizontal sync (pulse mode) |
| pkt_start | output | 1 | First cycle of the active packet |

## Verification
On the first cycle of a frame, the frame wrap, the capture of new configuration and the line's sync start all fall in the same cycle. If an input changes in the cycle right after a `frame_start`, it must be ignored for that whole frame. The bench provokes this by changing the line time exactly at a sampled `frame_start`. It then judges the case by the lengths of the two following frames: the first must keep the old length and the second must take the new one. The sync end and the packet start can also coincide when the back porch is zero, and the region checks cover that case.

// File: rtl/vid_timing_seq.sv
module vid_timing_seq #(
  parameter int HW = 16,
  parameter int VW = 12,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on,
  input  logic          cmd_mode,
  input  logic [1:0]    vid_mode,
  input  logic [5:0]    lp_en,
  input  logic [1:0]    lanes_m1,
  input  logic [PW-1:0] pix_per_line,
  input  logic [HW-1:0] hsync_cyc,
  input  logic [HW-1:0] hbp_cyc,
  input  logic [HW-1:0] line_cyc,
  input  logic [VW-1:0] vsync_lines,
  input  logic [VW-1:0] vbp_lines,
  input  logic [VW-1:0] vact_lines,
  input  logic [VW-1:0] vfp_lines,
  output logic [2:0]    region,
  output logic [1:0]    vphase,
  output logic          lp_allow,
  output logic          frame_start,
  output logic          sync_start,
  output logic          sync_end,
  output logic          pkt_start
);
  localparam int SW = ((HW > PW + 2) ? HW : PW + 2) + 2;
  localparam int TW = VW + 2;
  localparam logic [2:0] R_IDLE = 3'd0, R_SYNC = 3'd1, R_HBP = 3'd2,
                         R_ACT = 3'd3, R_HFP = 3'd4, R_VBLK = 3'd5;

  logic          run_q;
  logic [SW-1:0] hcnt;
  logic [TW-1:0] vcnt;
  logic [1:0]    s_mode, s_lanes;
  logic [5:0]    s_lp;
  logic [PW-1:0] s_pix;
  logic [HW-1:0] s_hsa, s_hbp, s_hline;
  logic [VW-1:0] s_vsa, s_vbp, s_vact, s_vfp;

  wire run_req = pwr_on & ~cmd_mode;

  wire [SW-1:0] act_cyc  = (SW'(s_pix) * SW'(3) + SW'(s_lanes)) / (SW'(s_lanes) + SW'(1));
  wire [SW-1:0] h_edge   = SW'(s_hsa) + SW'(s_hbp);
  wire [SW-1:0] act_end  = h_edge + act_cyc;
  wire [SW-1:0] len_raw  = (SW'(s_hline) > act_end) ? SW'(s_hline) : act_end;
  wire [SW-1:0] line_len = (len_raw == '0) ? SW'(1) : len_raw;

  wire [VW-1:0] vact1 = (s_vact == '0) ? VW'(1) : s_vact;
  wire [TW-1:0] b1    = TW'(s_vsa);
  wire [TW-1:0] b2    = b1 + TW'(s_vbp);
  wire [TW-1:0] b3    = b2 + TW'(vact1);
  wire [TW-1:0] vtot  = b3 + TW'(s_vfp);

  wire line_last  = (hcnt == line_len - SW'(1));
  wire frame_last = line_last && (vcnt == vtot - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; hcnt <= '0; vcnt <= '0;
      s_mode <= '0; s_lanes <= '0; s_lp <= '0; s_pix <= '0;
      s_hsa <= '0; s_hbp <= '0; s_hline <= '0;
      s_vsa <= '0; s_vbp <= '0; s_vact <= '0; s_vfp <= '0;
    end else if (!run_req) begin
      run_q <= 1'b0; hcnt <= '0; vcnt <= '0;
    end else if (!run_q || frame_last) begin
      run_q <= 1'b1; hcnt <= '0; vcnt <= '0;
      s_mode <= vid_mode; s_lanes <= lanes_m1; s_lp <= lp_en; s_pix <= pix_per_line;
      s_hsa <= hsync_cyc; s_hbp <= hbp_cyc; s_hline <= line_cyc;
      s_vsa <= vsync_lines; s_vbp <= vbp_lines; s_vact <= vact_lines; s_vfp <= vfp_lines;
    end else if (line_last) begin
      hcnt <= '0; vcnt <= vcnt + TW'(1);
    end else begin
      hcnt <= hcnt + SW'(1);
    end
  end

  assign vphase = (vcnt < b1) ? 2'd0 : (vcnt < b2) ? 2'd1 : (vcnt < b3) ? 2'd2 : 2'd3;

  always_comb begin
    region = R_IDLE;
    if (run_q) begin
      if (hcnt < SW'(s_hsa))   region = R_SYNC;
      else if (vphase != 2'd2) region = R_VBLK;
      else if (hcnt < h_edge)  region = R_HBP;
      else if (hcnt < act_end) region = R_ACT;
      else                     region = R_HFP;
    end
  end

  always_comb begin
    case (region)
      R_VBLK:  lp_allow = (vphase == 2'd0) ? s_lp[0] : (vphase == 2'd1) ? s_lp[1] : s_lp[2];
      R_HBP:   lp_allow = s_lp[3] & s_lp[4];
      R_HFP:   lp_allow = s_lp[3] & (s_lp[5] | (s_mode == 2'd2));
      default: lp_allow = 1'b0;
    endcase
  end

  assign sync_start  = run_q && (hcnt == '0);
  assign frame_start = sync_start && (vcnt == '0);
  assign sync_end    = run_q && (s_mode == 2'd0) && (s_hsa != '0) && (hcnt == SW'(s_hsa));
  assign pkt_start   = run_q && (vphase == 2'd2) && (act_cyc != '0) && (hcnt == h_edge);
endmodule

// File: rtl/vid_timing_seq_chk.sv
module vid_timing_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       cmd_mode,
  input logic [2:0] region,
  input logic [1:0] vphase,
  input logic       lp_allow,
  input logic       frame_start,
  input logic       sync_start,
  input logic       sync_end,
  input logic       pkt_start
);
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on || cmd_mode) |=> (region == 3'd0 && !frame_start)); // R1
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> sync_start); // R6
  AST_SYNC_END_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_end |-> (!sync_start && region != 3'd1 && region != 3'd0)); // R8
  AST_PKT_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (region == 3'd3 && vphase == 2'd2)); // R7
  AST_LP_ONLY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    lp_allow |-> (region == 3'd2 || region == 3'd4 || region == 3'd5)); // R9
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (region != 3'd0 && $past(region) != 3'd0 && vphase != $past(vphase))
      |-> (vphase > $past(vphase) || frame_start)); // R5
endmodule

bind vid_timing_seq vid_timing_seq_chk i_chk (.*);

// File: tb/test_vid_timing_seq.sv
module test_vid_timing_seq;
  localparam int CLK_PERIOD = 10;
  // hsa hbp hline pix lsel vsa vbp vact vfp mode mask exp_act exp_hlen
  localparam int TBL [4][13] = '{
    '{4, 3, 30,  8, 1, 2, 1, 3, 2, 0, 63, 12, 30},
    '{2, 2, 10, 10, 3, 1, 0, 2, 1, 1,  0,  8, 12},
    '{3, 1, 20,  5, 2, 1, 2, 0, 0, 2,  8,  5, 20},
    '{0, 2, 16,  4, 0, 0, 1, 2, 1, 0, 21, 12, 16}
  };

  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, cmd_mode = 1'b1;
  logic [1:0] vid_mode = '0, lanes_m1 = '0;
  logic [5:0] lp_en = '0;
  logic [13:0] pix_per_line = '0;
  logic [15:0] hsync_cyc = '0, hbp_cyc = '0, line_cyc = '0;
  logic [11:0] vsync_lines = '0, vbp_lines = '0, vact_lines = '0, vfp_lines = '0;
  logic [2:0] region;
  logic [1:0] vphase;
  logic lp_allow, frame_start, sync_start, sync_end, pkt_start;

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  int c_len, c_sync, c_hbp, c_act, c_hfp, c_vblk, c_lp, c_pkt, c_ss, c_se;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vid_timing_seq i_vid_timing_seq (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      check(1'b0, "watchdog", cyc_total, 100000);
      finish_run();
    end
  end

  task automatic wait_frame();
    int t = 0;
    while (!frame_start && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic measure_frame();
    c_len = 0; c_sync = 0; c_hbp = 0; c_act = 0; c_hfp = 0; c_vblk = 0;
    c_lp = 0; c_pkt = 0; c_ss = 0; c_se = 0;
    do begin
      c_len++;
      case (region)
        3'd1: c_sync++;
        3'd2: c_hbp++;
        3'd3: c_act++;
        3'd4: c_hfp++;
        3'd5: c_vblk++;
        default: ;
      endcase
      if (lp_allow) c_lp++;
      if (pkt_start) c_pkt++;
      if (sync_start) c_ss++;
      if (sync_end) c_se++;
      @(negedge clk);
    end while (!frame_start && c_len < 5000);
  endtask

  task automatic load(input int k);
    hsync_cyc = 16'(TBL[k][0]); hbp_cyc = 16'(TBL[k][1]); line_cyc = 16'(TBL[k][2]);
    pix_per_line = 14'(TBL[k][3]); lanes_m1 = 2'(TBL[k][4]);
    vsync_lines = 12'(TBL[k][5]); vbp_lines = 12'(TBL[k][6]);
    vact_lines = 12'(TBL[k][7]); vfp_lines = 12'(TBL[k][8]);
    vid_mode = 2'(TBL[k][9]); lp_en = 6'(TBL[k][10]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(region == 3'd0 && !frame_start && !sync_start && !pkt_start && !lp_allow,
          "R1 reset idle", region, 0);

    for (int k = 0; k < 4; k++) begin
      int nact, vtot, hlen, act, hfpw, burst, m, lpx;
      cmd_mode = 1'b1; load(k);
      @(negedge clk); @(negedge clk);
      pwr_on = 1'b1; cmd_mode = 1'b0;
      @(negedge clk);
      check(frame_start == 1'b1, "R1 start latency", frame_start, 1);
      wait_frame();
      measure_frame();
      nact = (TBL[k][7] == 0) ? 1 : TBL[k][7];
      vtot = TBL[k][5] + TBL[k][6] + nact + TBL[k][8];
      act = TBL[k][11]; hlen = TBL[k][12];
      hfpw = hlen - TBL[k][0] - TBL[k][1] - act;
      burst = (TBL[k][9] == 2) ? 1 : 0;
      m = TBL[k][10];
      lpx = (hlen - TBL[k][0]) * (TBL[k][5] * (m & 1) + TBL[k][6] * ((m >> 1) & 1)
            + TBL[k][8] * ((m >> 2) & 1))
            + nact * ((m >> 3) & 1) * (TBL[k][1] * ((m >> 4) & 1)
            + hfpw * (((m >> 5) & 1) | burst));
      check(c_len == hlen * vtot, "R5 frame length", c_len, hlen * vtot);
      check(c_sync == TBL[k][0] * vtot, "R2 sync cycles", c_sync, TBL[k][0] * vtot);
      check(c_hbp == TBL[k][1] * nact, "R2 back porch cycles", c_hbp, TBL[k][1] * nact);
      check(c_act == act * nact, "R3 active cycles", c_act, act * nact);
      check(c_hfp == hfpw * nact, "R4 front porch cycles", c_hfp, hfpw * nact);
      check(c_vblk == (hlen - TBL[k][0]) * (vtot - nact), "R5 vblank cycles",
            c_vblk, (hlen - TBL[k][0]) * (vtot - nact));
      check(c_ss == vtot, "R6 line strobes", c_ss, vtot);
      check(c_pkt == nact, "R7 packet strobes", c_pkt, nact);
      check(c_se == ((TBL[k][9] == 0 && TBL[k][0] != 0) ? vtot : 0), "R8 sync end strobes",
            c_se, (TBL[k][9] == 0 && TBL[k][0] != 0) ? vtot : 0);
      check(c_lp == lpx, "R9 low power cycles", c_lp, lpx);
    end

    // R10: change line time right at a frame start
    cmd_mode = 1'b1; load(0);
    @(negedge clk); @(negedge clk);
    cmd_mode = 1'b0;
    @(negedge clk);
    wait_frame();
    line_cyc = 16'd40;
    measure_frame();
    check(c_len == 240, "R10 old frame kept", c_len, 240);
    measure_frame();
    check(c_len == 320, "R10 new frame applied", c_len, 320);

    // R1: stop by command select and by power
    repeat (7) @(negedge clk);
    cmd_mode = 1'b1;
    @(negedge clk);
    check(region == 3'd0 && !sync_start, "R1 command mode idle", region, 0);
    cmd_mode = 1'b0;
    repeat (5) @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    check(region == 3'd0 && !frame_start, "R1 power off idle", region, 0);
    repeat (4) @(negedge clk);
    check(region == 3'd0, "R1 stays idle", region, 0);

    finish_run();
  end
endmodule